// File: doc/BRIEF.md
# Issue-Group Execution Port Assigner

This block sits at the allocate stage of an out-of-order core. Each cycle it receives a group of micro-ops in program order. Each slot carries a valid bit and a mask of the execution ports that can run it. The block chooses one legal port for every slot. It also keeps a per-port count of micro-ops that have been assigned to that port but have not yet been dispatched.

All slots in a group are decided at the same time, and every slot reads the port counts as they stood at the start of the cycle. A slot never sees the choices made by the other slots in its group, so several slots can pile onto one port while another legal port stays empty. A port counts as a candidate when its count is within one of the smallest count among the slot's allowed ports. When more than one port is a candidate, even-numbered slots take the lowest-numbered candidate and odd-numbered slots take the highest-numbered one.

The counts rise by the number of slots granted to each port and fall by one when that port reports a dispatch. If the group would push any port's count above the queue capacity, the whole group is held back.

Top module: `issue_port_assign`

## Requirements
- R1: After reset every port count reads zero, `stall` is low and no slot is granted.
- R2: A slot is granted only if its valid bit is set and its mask is non-empty. Mask bit p of slot i sits at bit i*NUM_PORTS+p of `slot_mask`. A slot with an empty mask, or with its valid bit clear, is never granted and changes no count.
- R3: A slot whose mask has exactly one bit set is assigned that port. The port is reported as a binary index in bits [i*PIDX_W +: PIDX_W] of `slot_port`.
- R4: Every slot is decided from the counts registered at the start of the cycle. Slots with the same mask and the same slot parity get the same port, whatever the other slots in the group choose.
- R5: The candidate ports of a slot are its allowed ports whose count is at most one above the smallest count among its allowed ports. Slots 0, 2 and 4 take the lowest-numbered candidate; slots 1, 3 and 5 take the highest-numbered candidate.
- R6: If one allowed port's count is at least two below the count of every other allowed port, every valid slot with that mask picks that port.
- R7: On the next cycle, each port count equals its old value plus the number of slots granted to it, minus one if `port_done` for that port was high and the old count was non-zero. A `port_done` pulse on a port whose count is zero has no effect.
- R8: `stall` is high when, for any port, the old count plus the number of requesting slots assigned to that port exceeds QCAP. While `stall` is high no slot is granted and no count goes up, but dispatch decrements still apply.
- R9: No port count ever exceeds QCAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | NUM_SLOTS | Valid bit for each slot of the group |
| slot_mask | input | NUM_SLOTS*NUM_PORTS | Allowed-port mask for each slot |
| port_done | input | NUM_PORTS | One micro-op dispatched from each port this cycle |
| slot_port | output | NUM_SLOTS*PIDX_W | Port chosen for each slot, as a binary index |
| slot_grant | output | NUM_SLOTS | Slot accepted into the chosen port this cycle |
| stall | output | 1 | Group held back because a port queue would overflow |
| port_cnt | output | NUM_PORTS*CNT_W | Registered count of queued micro-ops per port |

## Verification
The bench builds the block with six slots, four ports and a queue capacity of five. With these values a single group can overfill one port by itself, so the stall path is reachable without long warm-up sequences. The six slots cover three even and three odd positions, so both tie-break directions appear several times inside one group. Directed scenarios drive the counts into a known spread to exercise the within-one window, a clear minimum, a full queue and a dispatch at zero. A long stretch of pseudo-random groups is then checked against a model built from the requirements.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

  // Direction a slot uses when several candidate ports are close
  typedef enum logic {
    PICK_LOW  = 1'b0,
    PICK_HIGH = 1'b1
  } tie_dir_e;

  function automatic tie_dir_e slot_dir(input int slot);
    return (slot % 2 == 0) ? PICK_LOW : PICK_HIGH;
  endfunction

endpackage

// File: rtl/ipa_slot_pick.sv
module ipa_slot_pick
  import ipa_pkg::*;
#(
  parameter int       NUM_PORTS = 4,
  parameter int       CNT_W     = 4,
  parameter tie_dir_e DIR       = PICK_LOW,
  localparam int      PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS*CNT_W-1:0] cnt_i,
  input  logic [NUM_PORTS-1:0]       mask_i,
  output logic [PIDX_W-1:0]          port_o,
  output logic                       found_o
);

  logic [CNT_W-1:0]     min_c;
  logic [CNT_W:0]       lim_c;
  logic [NUM_PORTS-1:0] cand;

  // smallest count among the allowed ports
  always_comb begin
    min_c = '1;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (mask_i[p] && (cnt_i[p*CNT_W +: CNT_W] < min_c)) begin
        min_c = cnt_i[p*CNT_W +: CNT_W];
      end
    end
    lim_c = {1'b0, min_c} + (CNT_W+1)'(1);
  end

  // candidate window: within one of the minimum
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      cand[p] = mask_i[p] && ({1'b0, cnt_i[p*CNT_W +: CNT_W]} <= lim_c);
    end
  end

  generate
    if (DIR == PICK_LOW) begin : g_low
      always_comb begin
        port_o = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
          if (cand[p]) port_o = PIDX_W'(p);
        end
      end
    end else begin : g_high
      always_comb begin
        port_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (cand[p]) port_o = PIDX_W'(p);
        end
      end
    end
  endgenerate

  assign found_o = |mask_i;

  // R2: a chosen port is always one the mask allows
  always_comb begin
    if (found_o) begin
      a_r2_in_mask: assert (mask_i[port_o]);
    end
  end

  // R3: a one-hot mask forces its own port
  always_comb begin
    if ($onehot(mask_i)) begin
      a_r3_single_port: assert (mask_i == (NUM_PORTS'(1) << port_o));
    end
  end

endmodule

// File: rtl/ipa_port_ctr.sv
module ipa_port_ctr #(
  parameter int  QCAP   = 8,
  parameter int  ADD_W  = 3,
  parameter int  ADD_MX = 4,
  localparam int CNT_W  = $clog2(QCAP + 1),
  localparam int SUM_W  = $clog2(QCAP + ADD_MX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add_i,
  input  logic             inc_en_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             over_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [SUM_W-1:0] sum_add;
  logic [SUM_W-1:0] sum_nxt;

  assign sum_add = SUM_W'(cnt_q) + SUM_W'(add_i);
  assign over_o  = sum_add > SUM_W'(QCAP);

  // next-state logic
  always_comb begin
    sum_nxt = SUM_W'(cnt_q);
    if (inc_en_i) sum_nxt = sum_add;
    if (done_i && (cnt_q != '0)) sum_nxt = sum_nxt - SUM_W'(1);
    cnt_d = sum_nxt[CNT_W-1:0];
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9: queue occupancy bounded by capacity
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(QCAP));

  // R8: a held-back group never raises the count
  a_r8_stall_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_en_i |=> cnt_q <= $past(cnt_q));

  // R7: dispatch at zero with nothing added leaves zero
  a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && (add_i == '0 || !inc_en_i)) |=> cnt_q == '0);

endmodule

// File: rtl/issue_port_assign.sv
module issue_port_assign
  import ipa_pkg::*;
#(
  parameter int  NUM_SLOTS = 4,
  parameter int  NUM_PORTS = 4,
  parameter int  QCAP      = 8,
  localparam int PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W     = $clog2(QCAP + 1),
  localparam int ADD_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOTS-1:0]           slot_vld,
  input  logic [NUM_SLOTS*NUM_PORTS-1:0] slot_mask,
  input  logic [NUM_PORTS-1:0]           port_done,
  output logic [NUM_SLOTS*PIDX_W-1:0]    slot_port,
  output logic [NUM_SLOTS-1:0]           slot_grant,
  output logic                           stall,
  output logic [NUM_PORTS*CNT_W-1:0]     port_cnt
);

  logic [NUM_SLOTS-1:0] found;
  logic [NUM_SLOTS-1:0] req;
  logic [PIDX_W-1:0]    sel    [NUM_SLOTS];
  logic [ADD_W-1:0]     add_p  [NUM_PORTS];
  logic [NUM_PORTS-1:0] over_p;

  // one picker per slot, all reading the same count snapshot
  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      ipa_slot_pick #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .DIR       (slot_dir(s))
      ) pick_i (
        .cnt_i   (port_cnt),
        .mask_i  (slot_mask[s*NUM_PORTS +: NUM_PORTS]),
        .port_o  (sel[s]),
        .found_o (found[s])
      );
      assign slot_port[s*PIDX_W +: PIDX_W] = sel[s];
    end
  endgenerate

  assign req = slot_vld & found;

  // number of requesting slots that landed on each port
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      add_p[p] = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (req[s] && (sel[s] == PIDX_W'(p))) add_p[p] = add_p[p] + ADD_W'(1);
      end
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ipa_port_ctr #(
        .QCAP   (QCAP),
        .ADD_W  (ADD_W),
        .ADD_MX (NUM_SLOTS)
      ) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_i    (add_p[p]),
        .inc_en_i (!stall),
        .done_i   (port_done[p]),
        .cnt_o    (port_cnt[p*CNT_W +: CNT_W]),
        .over_o   (over_p[p])
      );
    end
  endgenerate

  assign stall      = |over_p;
  assign slot_grant = stall ? '0 : req;

  // R4: slots 0 and 2 share parity; same mask means same port
  a_r4_same_mask_same_port: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_mask[0 +: NUM_PORTS] == slot_mask[2*NUM_PORTS +: NUM_PORTS])
      |-> (sel[0] == sel[2]));

  // R2: a granted slot always had a valid request
  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_grant & ~slot_vld) == '0);

endmodule

// File: tb/issue_port_assign_tb_top.sv
module issue_port_assign_tb_top;

  localparam int NS = 6;
  localparam int NP = 4;
  localparam int QC = 5;
  localparam int PW = 2;
  localparam int CW = 3;

  logic            clk;
  logic            rst_n;
  logic [NS-1:0]   vld;
  logic [NS*NP-1:0] mask;
  logic [NP-1:0]   done;
  logic [NS*PW-1:0] slot_port;
  logic [NS-1:0]   slot_grant;
  logic            stall;
  logic [NP*CW-1:0] port_cnt;

  int n_chk;
  int n_err;
  int mc [NP];
  int g_port [NS];
  logic [NS-1:0] g_grant;
  logic g_stall;

  issue_port_assign #(.NUM_SLOTS(NS), .NUM_PORTS(NP), .QCAP(QC)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_vld   (vld),
    .slot_mask  (mask),
    .port_done  (done),
    .slot_port  (slot_port),
    .slot_grant (slot_grant),
    .stall      (stall),
    .port_cnt   (port_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_pick(input int s, input logic [NP-1:0] m);
    int mn;
    mn = 1000;
    for (int p = 0; p < NP; p++) if (m[p] && mc[p] < mn) mn = mc[p];
    if (s % 2 == 0) begin
      for (int p = 0; p < NP; p++) if (m[p] && mc[p] <= mn + 1) return p;
    end else begin
      for (int p = NP - 1; p >= 0; p--) if (m[p] && mc[p] <= mn + 1) return p;
    end
    return 0;
  endfunction

  // one group: drive, check choices, clock, check counts
  task automatic step(input logic [NS-1:0] v, input logic [NS*NP-1:0] m,
                      input logic [NP-1:0] d);
    int ep [NS];
    int ad [NP];
    bit rq [NS];
    bit est;
    @(negedge clk);
    vld = v; mask = m; done = d;
    #1;
    for (int p = 0; p < NP; p++) ad[p] = 0;
    for (int s = 0; s < NS; s++) begin
      rq[s] = v[s] && (m[s*NP +: NP] != '0);
      ep[s] = m_pick(s, m[s*NP +: NP]);
      if (rq[s]) ad[ep[s]]++;
    end
    est = 1'b0;
    for (int p = 0; p < NP; p++) if (mc[p] + ad[p] > QC) est = 1'b1;
    chk(stall == est, "R8 stall", int'(stall), int'(est));
    for (int s = 0; s < NS; s++) begin
      g_port[s] = int'(slot_port[s*PW +: PW]);
      if (rq[s]) chk(g_port[s] == ep[s], "R5 port choice", g_port[s], ep[s]);
      chk(slot_grant[s] == (rq[s] && !est), "R2 grant", int'(slot_grant[s]),
          int'(rq[s] && !est));
    end
    g_grant = slot_grant;
    g_stall = stall;
    for (int p = 0; p < NP; p++) begin
      int old;
      old = mc[p];
      if (!est) mc[p] += ad[p];
      if (d[p] && old > 0) mc[p] -= 1;
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      chk(int'(port_cnt[p*CW +: CW]) == mc[p], "R7 count", int'(port_cnt[p*CW +: CW]), mc[p]);
      chk(mc[p] <= QC, "R9 bound", mc[p], QC);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < QC; i++) step('0, '0, '1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk(port_cnt[p*CW +: CW] == '0, "R1 count", int'(port_cnt[p*CW +: CW]), 0);
    chk(stall == 1'b0, "R1 stall", int'(stall), 0);
    chk(slot_grant == '0, "R1 grant", int'(slot_grant), 0);
  endtask

  task automatic t_single();
    drain();
    step(6'b111111, {4'b0001, 4'b0100, 4'b0010, 4'b1000, 4'b0001, 4'b0100}, '0);
    chk(g_port[0] == 2, "R3 slot0", g_port[0], 2);
    chk(g_port[1] == 0, "R3 slot1", g_port[1], 0);
    chk(g_port[2] == 3, "R3 slot2", g_port[2], 3);
    chk(g_port[3] == 1, "R3 slot3", g_port[3], 1);
  endtask

  task automatic t_snapshot();
    drain();
    step(6'b111111, {6{4'b0011}}, '0);
    for (int s = 0; s < NS; s++) chk(g_port[s] == s % 2, "R4 snapshot", g_port[s], s % 2);
    chk(int'(port_cnt[0 +: CW]) == 3, "R4 port0 count", int'(port_cnt[0 +: CW]), 3);
    chk(int'(port_cnt[CW +: CW]) == 3, "R4 port1 count", int'(port_cnt[CW +: CW]), 3);
  endtask

  task automatic t_clear_min();
    // counts now 3,3,0,0
    step(6'b001111, {6{4'b0111}}, '0);
    for (int s = 0; s < 4; s++) chk(g_port[s] == 2, "R6 clear minimum", g_port[s], 2);
    chk(g_grant == 6'b001111, "R6 grant", int'(g_grant), 15);
  endtask

  task automatic t_window();
    // counts now 3,3,4,0; mask p0..p2 puts all three in the window
    step(6'b000011, {6{4'b0111}}, '0);
    chk(g_port[0] == 0, "R5 even low", g_port[0], 0);
    chk(g_port[1] == 2, "R5 odd high", g_port[1], 2);
  endtask

  task automatic t_overflow();
    // counts now 4,3,5,0; port2 full
    step(6'b000001, {5'b0, 4'b0100}, 4'b0001);
    chk(g_stall == 1'b1, "R8 stall on full", int'(g_stall), 1);
    chk(g_grant == '0, "R8 no grant", int'(g_grant), 0);
    chk(int'(port_cnt[2*CW +: CW]) == 5, "R8 full held", int'(port_cnt[2*CW +: CW]), 5);
    chk(int'(port_cnt[0 +: CW]) == 3, "R8 done applies", int'(port_cnt[0 +: CW]), 3);
  endtask

  task automatic t_done_zero();
    drain();
    step('0, '0, '1);
    for (int p = 0; p < NP; p++) chk(port_cnt[p*CW +: CW] == '0, "R7 done at zero", int'(port_cnt[p*CW +: CW]), 0);
  endtask

  task automatic t_empty();
    drain();
    step(6'b000001, {20'b0, 4'b0000}, '0);
    chk(g_grant == '0, "R2 empty mask", int'(g_grant), 0);
    step(6'b000000, {6{4'b1111}}, '0);
    chk(g_grant == '0, "R2 invalid slot", int'(g_grant), 0);
    for (int p = 0; p < NP; p++) chk(port_cnt[p*CW +: CW] == '0, "R2 no count change", int'(port_cnt[p*CW +: CW]), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      step(NS'($urandom), (NS*NP)'({$urandom, $urandom}), NP'($urandom));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    for (int p = 0; p < NP; p++) mc[p] = 0;
    vld = '0; mask = '0; done = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_snapshot();
    t_clear_min();
    t_window();
    t_overflow();
    t_done_zero();
    t_empty();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule